// File: doc/BRIEF.md
# Dual-Port 4x4 Register File

This block is a small storage array of four 4-bit words with two independent ports. One port writes: it takes a word address, a data word and an active-low write strobe. The other port reads: it takes its own word address and an active-low read strobe, and it presents the addressed word on a data bus. Because the two ports decode their addresses separately, one word can be updated while another is read in the same cycle. Reading never changes the stored contents.

Writes are committed on the rising clock edge. A combinational bypass makes a read that targets the word being written return the incoming data in the same cycle, which gives the cell transparent behaviour. When the read strobe is inactive, an output-enable flag is deasserted to stand for a floating bus, and the data bus is held at all zeros. A synchronous active-high reset, selectable by parameter, clears every word for test.

Top module: `dual_port_regfile`

## Requirements
- R1: With reset enabled by parameter, a clock edge with `rst` high sets all four words to zero, and reset takes priority over a write in the same cycle.
- R2: A clock edge with `wr_en_n` low stores `wr_data` unchanged (not inverted) in the word selected by `wr_addr`.
- R3: While `wr_en_n` is high, a clock edge leaves every stored word unchanged, whatever `wr_addr` and `wr_data` are.
- R4: While `rd_en_n` is high, `rd_oe` is 0 and `rd_data` is all zeros in the same cycle.
- R5: While `rd_en_n` is low and no write targets the read word, `rd_oe` is 1 and `rd_data` equals the stored word at `rd_addr` in the same cycle.
- R6: A write to one word and a read of a different word in the same cycle both take effect: the read shows that word's stored value and the write lands at the clock edge.
- R7: While `rd_en_n` and `wr_en_n` are both low and `rd_addr` equals `wr_addr`, `rd_data` equals `wr_data` in the same cycle.
- R8: Reading is non-destructive: a word read on several cycles keeps its value.
- R9: A write changes only the addressed word; the other three words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all words |
| wr_addr | input | 2 | Word selected for writing |
| wr_data | input | 4 | Data word to store |
| wr_en_n | input | 1 | Active-low write strobe |
| rd_addr | input | 2 | Word selected for reading |
| rd_en_n | input | 1 | Active-low read strobe |
| rd_data | output | 4 | Read word, zero while output is off |
| rd_oe | output | 1 | High when the read bus is driven |

## Verification
Reads are tried with the write port idle, with a write to a different word, and with a write to the same word, which separates the plain array path from the bypass path and shows that a neighbour write does not leak into the read word. Writes with the strobe inactive, followed by reads of every word, tell a correct write gate apart from one that stores anyway. Walking and mixed data values in all four words expose swapped address decoding or inverted storage, and a reset issued mid-run, overlapping a write, shows reset priority.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int unsigned RF_WORDS_DEF = 4;
    localparam int unsigned RF_WIDTH_DEF = 4;

    // Where the read port takes its word from in a given cycle.
    typedef enum logic [1:0] {
        RD_SRC_OFF    = 2'd0,
        RD_SRC_ARRAY  = 2'd1,
        RD_SRC_BYPASS = 2'd2
    } rd_src_e;

    function automatic rd_src_e pick_rd_src(input logic rd_on, input logic wr_hit);
        if (!rd_on)
            return RD_SRC_OFF;
        else if (wr_hit)
            return RD_SRC_BYPASS;
        else
            return RD_SRC_ARRAY;
    endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned WORDS  = regfile_pkg::RF_WORDS_DEF,
    parameter int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en_n,
    output logic [WORDS-1:0]  wr_sel
);

    // One select line per word: address match AND strobe active.
    for (genvar g = 0; g < WORDS; g++) begin : g_sel
        assign wr_sel[g] = !wr_en_n && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        assert (wr_en_n ? (wr_sel == '0) : $onehot(wr_sel))
            else $error("assert_sel_onehot_R9");
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned WORDS    = regfile_pkg::RF_WORDS_DEF,
    parameter int unsigned WIDTH    = regfile_pkg::RF_WIDTH_DEF,
    parameter bit          RESET_EN = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WORDS-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [WORDS-1:0][WIDTH-1:0] mem_q
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (RESET_EN && rst)
                mem_q[g] <= '0;
            else if (wr_sel[g])
                mem_q[g] <= wr_data;
        end

        assert_write_R2: assert property (@(posedge clk) disable iff (rst)
            wr_sel[g] |=> mem_q[g] == $past(wr_data));

        assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !wr_sel[g] |=> $stable(mem_q[g]));
    end

    if (RESET_EN) begin : g_rst_chk
        assert_clear_R1: assert property (@(posedge clk)
            rst |=> mem_q == '0);
    end

endmodule

// File: rtl/rf_rd_select.sv
module rf_rd_select
    import regfile_pkg::*;
#(
    parameter int unsigned WORDS  = RF_WORDS_DEF,
    parameter int unsigned WIDTH  = RF_WIDTH_DEF,
    parameter int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][WIDTH-1:0] mem_q,
    input  logic [WORDS-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic                        rd_en_n,
    output logic [WIDTH-1:0]            rd_data,
    output logic                        rd_oe
);

    rd_src_e src;

    always_comb begin
        src = pick_rd_src(!rd_en_n, wr_sel[rd_addr]);
        unique case (src)
            RD_SRC_BYPASS: rd_data = wr_data;
            RD_SRC_ARRAY:  rd_data = mem_q[rd_addr];
            default:       rd_data = '0;
        endcase
        rd_oe = (src != RD_SRC_OFF);
    end

endmodule

// File: rtl/dual_port_regfile.sv
module dual_port_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned WORDS    = RF_WORDS_DEF,
    parameter int unsigned WIDTH    = RF_WIDTH_DEF,
    parameter bit          RESET_EN = 1'b1,
    localparam int unsigned ADDR_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en_n,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_oe
);

    logic [WORDS-1:0]            wr_sel;
    logic [WORDS-1:0][WIDTH-1:0] mem_q;

    rf_wr_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_dec (
        .wr_addr (wr_addr),
        .wr_en_n (wr_en_n),
        .wr_sel  (wr_sel)
    );

    rf_store #(.WORDS(WORDS), .WIDTH(WIDTH), .RESET_EN(RESET_EN)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mem_q   (mem_q)
    );

    rf_rd_select #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
        .mem_q   (mem_q),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_en_n (rd_en_n),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en_n |=> mem_q == $past(mem_q));

    assert_off_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en_n |-> (!rd_oe && rd_data == '0));

    assert_array_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_n && (wr_en_n || wr_addr != rd_addr)) |-> (rd_oe && rd_data == mem_q[rd_addr]));

    assert_through_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_n && !wr_en_n && wr_addr == rd_addr) |-> (rd_oe && rd_data == wr_data));

    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_n && (wr_en_n || wr_addr != rd_addr)) |=> mem_q[$past(rd_addr)] == $past(rd_data));

endmodule

// File: tb/dual_port_regfile_bench.sv
`timescale 1ns/1ps
module dual_port_regfile_bench;

    typedef struct {
        logic       oe;
        logic [3:0] data;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       wr_en_n = 1'b1;
    logic [1:0] rd_addr = '0;
    logic       rd_en_n = 1'b1;
    logic [3:0] rd_data;
    logic       rd_oe;

    int checks = 0;
    int errors = 0;
    logic [3:0] ref_mem [4];
    exp_t exp_q [$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_port_regfile u_dual_port_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_en_n (wr_en_n),
        .rd_addr (rd_addr),
        .rd_en_n (rd_en_n),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    // Driver: apply one cycle of stimulus and queue the expected read result.
    task automatic drive(input logic r, input logic wen_n, input logic [1:0] wa,
                         input logic [3:0] wd, input logic ren_n, input logic [1:0] ra,
                         input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en_n = wen_n; wr_addr = wa; wr_data = wd;
        rd_en_n = ren_n; rd_addr = ra;
        e.tag = tag;
        if (ren_n) begin
            e.oe = 1'b0; e.data = 4'h0;
        end else begin
            e.oe = 1'b1;
            e.data = (!wen_n && wa == ra) ? wd : ref_mem[ra];
        end
        exp_q.push_back(e);
        if (r) begin
            for (int i = 0; i < 4; i++) ref_mem[i] = 4'h0;
        end else if (!wen_n) begin
            ref_mem[wa] = wd;
        end
    endtask

    task automatic rd(input logic [1:0] ra, input string tag);
        drive(1'b0, 1'b1, 2'd0, 4'h0, 1'b0, ra, tag);
    endtask

    // Monitor: compare design output against queued expectations mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rd_oe !== e.oe || rd_data !== e.data) begin
                    errors++;
                    $display("FAIL %s: got oe=%b data=%h expected oe=%b data=%h",
                             e.tag, rd_oe, rd_data, e.oe, e.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) ref_mem[i] = 4'h0;
        repeat (2) @(posedge clk);
        // R1: contents after reset
        for (int i = 0; i < 4; i++) rd(2'(i), "R1 reset contents");
        // R4: read disabled with idle write port
        drive(1'b0, 1'b1, 2'd0, 4'h0, 1'b1, 2'd2, "R4 output off");
        // R2 + R4: fill all words while read is off
        drive(1'b0, 1'b0, 2'd0, 4'h5, 1'b1, 2'd0, "R4 off during write");
        drive(1'b0, 1'b0, 2'd1, 4'hA, 1'b1, 2'd1, "R4 off during write");
        drive(1'b0, 1'b0, 2'd2, 4'h3, 1'b1, 2'd2, "R4 off during write");
        drive(1'b0, 1'b0, 2'd3, 4'hC, 1'b1, 2'd3, "R4 off during write");
        for (int i = 0; i < 4; i++) rd(2'(i), "R2 R5 stored word");
        // R8: repeated reads keep the word
        rd(2'd1, "R8 reread");
        rd(2'd1, "R8 reread");
        // R3: strobe inactive, data and address present
        drive(1'b0, 1'b1, 2'd1, 4'hF, 1'b1, 2'd0, "R3 inhibited write");
        drive(1'b0, 1'b1, 2'd2, 4'h0, 1'b0, 2'd2, "R3 inhibited write read");
        for (int i = 0; i < 4; i++) rd(2'(i), "R3 contents unchanged");
        // R6: write one word, read another, same cycle
        drive(1'b0, 1'b0, 2'd2, 4'h9, 1'b0, 2'd0, "R6 concurrent other word");
        drive(1'b0, 1'b0, 2'd0, 4'h6, 1'b0, 2'd2, "R6 read freshly written");
        // R9: neighbours unchanged
        for (int i = 0; i < 4; i++) rd(2'(i), "R9 only target changed");
        // R7: same-word write-through
        drive(1'b0, 1'b0, 2'd3, 4'h6, 1'b0, 2'd3, "R7 write through");
        drive(1'b0, 1'b0, 2'd3, 4'h1, 1'b0, 2'd3, "R7 write through");
        rd(2'd3, "R7 value kept");
        // Walking patterns mixing both read paths
        for (int k = 0; k < 16; k++) begin
            logic [1:0] wa;
            logic [1:0] ra;
            wa = 2'(k);
            ra = (k % 3 == 0) ? wa : 2'(k + 1);
            drive(1'b0, 1'b0, wa, 4'(1 << (k % 4)) ^ 4'(k), 1'b0, ra,
                  (wa == ra) ? "R7 pattern" : "R6 pattern");
        end
        for (int i = 0; i < 4; i++) rd(2'(i), "R9 pattern contents");
        // R1: reset overlapping a write, then contents
        drive(1'b1, 1'b0, 2'd2, 4'hE, 1'b1, 2'd0, "R4 off during reset");
        for (int i = 0; i < 4; i++) rd(2'(i), "R1 reset beats write");
        drive(1'b0, 1'b1, 2'd0, 4'h0, 1'b1, 2'd0, "R4 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule